// File: doc/BRIEF.md
# Holdover Tuning History Tracker

This block owns the frequency-control word that drives the oscillator DAC of a synchronisation clock. A two-bit mode select chooses where the word comes from. In free run it is a fixed centre word. In either locked mode it is the live tuning word from the loop filter. In holdover it is a stored history value, which is the average of the loop words seen over one complete history window.

The DAC word is updated only on a strobe from an 8 kHz tick. A one-cycle write strobe goes out only when the value actually changes. A tuning-limit alarm is raised while the word lies in the outer tenth at either end of the unsigned range.

The history window is counted in strobes from a seconds tick, 40 seconds by default. Inside each window the first 2^AVG_SHIFT samples, taken on 8 kHz ticks, are summed and then shifted down. The average is committed only when the window closes with its full sample count.

Top module: `holdover_tune_tracker`

## Requirements
- R1: The mode select encodes 00 as free run, which selects the centre word. It encodes 01 and 10 as the two locked modes, which select the live loop word, and 11 as holdover.
- R2: The DAC word changes only in the cycle after an 8 kHz tick has been sampled high. Between ticks it holds, whatever the inputs do.
- R3: The write strobe is high for exactly one cycle, in the cycle the DAC word takes a new value. It stays low when a tick brings the same value.
- R4: While locked, each window of WIN_SECS seconds ticks accumulates the loop word on its first 2^AVG_SHIFT 8 kHz ticks. At the window's last seconds tick, the sum shifted right by AVG_SHIFT becomes the history value. Later samples in the same window are ignored.
- R5: A window that closes with fewer than 2^AVG_SHIFT samples leaves the history unchanged. Any cycle outside the two locked modes restarts the window from zero.
- R6: In holdover the word is the history value once a first full window has been committed. Before that, it is the centre word.
- R7: tvl_alarm is high exactly when dac_word < floor(2^WORD_W/10) or dac_word > 2^WORD_W-1-floor(2^WORD_W/10).
- R8: After reset dac_word is 0 and dac_wr is 0, and no history is valid.
- R9: On a change from holdover back to a locked mode, the word follows the live loop word from the next 8 kHz tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Operating mode (00 free, 01/10 locked, 11 holdover) |
| loop_word | input | WORD_W | Tuning word from the loop filter |
| center_word | input | WORD_W | Programmable free-run centre word |
| tick_8k | input | 1 | One-cycle 8 kHz update strobe |
| tick_1s | input | 1 | One-cycle seconds strobe |
| dac_word | output | WORD_W | Word presented to the DAC |
| dac_wr | output | 1 | One-cycle DAC write strobe |
| tvl_alarm | output | 1 | Tuning near-limit alarm |

## Verification
The hardest situation to reach is a history commit that must be rejected: a window whose sample count is short, or a window interrupted by leaving the locked modes even though the total count across the interruption adds up to a full window. The bench uses a 2-second window of 4 samples and steps the 8 kHz and seconds strobes by hand. It first commits a known average. It then builds a short window and an interrupted window, and after each one enters holdover to show that the earlier average is still in place.

// File: rtl/holdover_tune_tracker.sv
module holdover_tune_tracker #(
  parameter int WORD_W    = 16,
  parameter int WIN_SECS  = 40,
  parameter int AVG_SHIFT = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic [WORD_W-1:0] loop_word,
  input  logic [WORD_W-1:0] center_word,
  input  logic              tick_8k,
  input  logic              tick_1s,
  output logic [WORD_W-1:0] dac_word,
  output logic              dac_wr,
  output logic              tvl_alarm
);
  localparam int ACC_W = WORD_W + AVG_SHIFT;
  localparam int CNT_W = AVG_SHIFT + 1;
  localparam int SEC_W = $clog2(WIN_SECS + 1);
  localparam logic [CNT_W-1:0]  FULL     = {1'b1, {AVG_SHIFT{1'b0}}};
  localparam logic [SEC_W-1:0]  LAST_SEC = SEC_W'(WIN_SECS - 1);
  localparam logic [WORD_W-1:0] MARGIN   = WORD_W'((2 ** WORD_W) / 10);
  localparam logic [WORD_W-1:0] HI_EDGE  = ~MARGIN;

  logic [ACC_W-1:0]  acc;
  logic [CNT_W-1:0]  n_samp;
  logic [SEC_W-1:0]  n_sec;
  logic [WORD_W-1:0] hist;
  logic              hist_ok;
  logic [WORD_W-1:0] target;

  wire locked  = (mode_sel == 2'b01) || (mode_sel == 2'b10);
  wire hold    = (mode_sel == 2'b11);
  wire win_end = locked && tick_1s && (n_sec == LAST_SEC);
  wire take    = locked && tick_8k && !win_end && !n_samp[AVG_SHIFT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      n_samp  <= '0;
      n_sec   <= '0;
      hist    <= '0;
      hist_ok <= 1'b0;
    end else if (!locked) begin
      acc    <= '0;
      n_samp <= '0;
      n_sec  <= '0;
    end else if (win_end) begin
      if (n_samp == FULL) begin
        hist    <= acc[ACC_W-1:AVG_SHIFT];
        hist_ok <= 1'b1;
      end
      acc    <= '0;
      n_samp <= '0;
      n_sec  <= '0;
    end else begin
      if (tick_1s) n_sec <= n_sec + 1'b1;
      if (take) begin
        acc    <= acc + ACC_W'(loop_word);
        n_samp <= n_samp + 1'b1;
      end
    end
  end

  always_comb begin
    if (locked)                target = loop_word;
    else if (hold && hist_ok)  target = hist;
    else                       target = center_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_word <= '0;
      dac_wr   <= 1'b0;
    end else if (tick_8k && (target != dac_word)) begin
      dac_word <= target;
      dac_wr   <= 1'b1;
    end else begin
      dac_wr <= 1'b0;
    end
  end

  assign tvl_alarm = (dac_word < MARGIN) || (dac_word > HI_EDGE);
endmodule

// File: rtl/holdover_tune_tracker_chk.sv
module holdover_tune_tracker_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_sel,
  input logic [WORD_W-1:0] loop_word,
  input logic [WORD_W-1:0] center_word,
  input logic              tick_8k,
  input logic [WORD_W-1:0] dac_word,
  input logic              dac_wr,
  input logic              tvl_alarm
);
  localparam logic [WORD_W-1:0] QLO = WORD_W'(2 ** (WORD_W - 2));
  localparam logic [WORD_W-1:0] QHI = WORD_W'(3 * (2 ** (WORD_W - 2)));

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_8k |=> $stable(dac_word));

  a_r3_wr_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
    dac_wr |-> (dac_word != $past(dac_word)));

  a_r3_change_has_wr: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr |-> $stable(dac_word));

  a_r3_wr_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    dac_wr |-> $past(tick_8k));

  a_r1_locked_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_8k && (mode_sel == 2'b01 || mode_sel == 2'b10)) |=> (dac_word == $past(loop_word)));

  a_r1_free_center: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_8k && mode_sel == 2'b00) |=> (dac_word == $past(center_word)));

  a_r7_mid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_word >= QLO && dac_word < QHI) |-> !tvl_alarm);
endmodule

bind holdover_tune_tracker holdover_tune_tracker_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .loop_word(loop_word),
  .center_word(center_word), .tick_8k(tick_8k), .dac_word(dac_word),
  .dac_wr(dac_wr), .tvl_alarm(tvl_alarm));

// File: tb/holdover_tune_tracker_tb_top.sv
`timescale 1ns/1ps
module holdover_tune_tracker_tb_top;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [W-1:0] loop_word = '0;
  logic [W-1:0] center_word = '0;
  logic tick_8k = 1'b0;
  logic tick_1s = 1'b0;
  logic [W-1:0] dac_word;
  logic dac_wr;
  logic tvl_alarm;
  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  holdover_tune_tracker #(.WORD_W(W), .WIN_SECS(2), .AVG_SHIFT(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .loop_word(loop_word),
    .center_word(center_word), .tick_8k(tick_8k), .tick_1s(tick_1s),
    .dac_word(dac_word), .dac_wr(dac_wr), .tvl_alarm(tvl_alarm));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick8();
    @(negedge clk) tick_8k = 1'b1;
    @(negedge clk) tick_8k = 1'b0;
  endtask

  task automatic tick_sec();
    @(negedge clk) tick_1s = 1'b1;
    @(negedge clk) tick_1s = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int tvl_exp(input int w);
    return (w < 25 || w > 230) ? 1 : 0;
  endfunction

  initial begin
    int prev;
    idle(3);
    chk("R8 reset word", dac_word, 0);
    chk("R8 reset wr", dac_wr, 0);
    chk("R7 reset tvl", tvl_alarm, 1);
    rst_n = 1'b1;
    center_word = 8'd100;
    idle(3);
    chk("R2 no tick no change", dac_word, 0);
    tick8();
    chk("R1 free run centre", dac_word, 100);
    chk("R3 wr on change", dac_wr, 1);
    idle(1);
    chk("R3 wr one cycle", dac_wr, 0);
    tick8();
    chk("R3 no wr same value", dac_wr, 0);
    mode_sel = 2'b11;
    center_word = 8'd120;
    tick8();
    chk("R6 holdover without history uses centre", dac_word, 120);
    mode_sel = 2'b01; loop_word = 8'd150;
    tick8();
    chk("R1 locked ref1 follows loop", dac_word, 150);
    loop_word = 8'd160;
    idle(5);
    chk("R2 held between ticks", dac_word, 150);
    mode_sel = 2'b00; idle(2);
    mode_sel = 2'b10;
    loop_word = 8'd40; tick8();
    chk("R1 locked ref2 follows loop", dac_word, 40);
    loop_word = 8'd44; tick8();
    loop_word = 8'd48; tick8();
    loop_word = 8'd52; tick8();
    loop_word = 8'd250; tick8();
    tick_sec(); tick_sec();
    mode_sel = 2'b11; tick8();
    chk("R4 R6 holdover uses average of first four", dac_word, 46);
    mode_sel = 2'b01; loop_word = 8'd10;
    tick8(); tick8(); tick8();
    tick_sec(); tick_sec();
    mode_sel = 2'b11; tick8();
    chk("R5 short window discarded", dac_word, 46);
    mode_sel = 2'b01; loop_word = 8'd200;
    tick8(); tick8();
    mode_sel = 2'b00; idle(2);
    mode_sel = 2'b01;
    tick8(); tick8();
    tick_sec(); tick_sec();
    mode_sel = 2'b11; tick8();
    chk("R5 interrupted window discarded", dac_word, 46);
    mode_sel = 2'b01; loop_word = 8'd200; tick8();
    chk("R9 back to loop after holdover", dac_word, 200);
    loop_word = 8'd100; tick8(); tick8();
    loop_word = 8'd104; tick8();
    tick_sec(); tick_sec();
    mode_sel = 2'b11; tick8();
    chk("R4 second window average", dac_word, 126);
    mode_sel = 2'b01;
    prev = 126;
    for (int w = 0; w < 256; w++) begin
      loop_word = W'(w);
      tick8();
      chk("R1 sweep word", dac_word, w);
      chk("R3 sweep wr", dac_wr, (w != prev) ? 1 : 0);
      chk("R7 sweep tvl", tvl_alarm, tvl_exp(w));
      prev = w;
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule